// File: doc/BRIEF.md
# Serial DAC Sample Frame Writer

This block pushes one 12-bit sample to a two-channel serial DAC each time a sample strobe arrives. Each write is a single 16-bit word clocked out as bus master: a fixed 4-bit control nibble first, then the 12 payload bits. The control nibble addresses the first output channel at unity gain with the output stage switched on. A parameter chooses whether the sample is halved (a one-bit right shift) before it is placed in the word.

A strobe is accepted only when the block is idle. After acceptance a programmable settling wait runs before chip select drops. The serial clock then runs at the system clock divided by a parameter, idles low, and the data line changes only on its falling edge. Chip select returns high after the sixteenth bit and stays high for one serial clock period before the block is idle again. A one-cycle done pulse marks the end of each word. A strobe that arrives while a word is in progress is dropped and sets a sticky overrun flag.

Top module: `dac_frame_tx`

## Requirements
- R1: Every word is 16 bits sent MSB first. Bits 15..12 are the control nibble 4'b0011 and bits 11..0 are the payload.
- R2: With SCALE_HALF=1 the payload is the captured sample shifted right by one. With SCALE_HALF=0 it is the sample unchanged.
- R3: While chip select is high, sclk is low. During a word, sdo does not change while sclk is high, and sclk has exactly 16 rising edges.
- R4: The first sclk rising edge comes HALF_DIV clock cycles after chip select falls. sclk is high for 16*HALF_DIV cycles in each word.
- R5: Chip select falls exactly SETUP_CYC clock cycles after the clock edge that accepts the strobe.
- R6: Chip select stays low for exactly 32*HALF_DIV cycles and rises with the sixteenth falling sclk edge.
- R7: done is high for exactly one cycle per word, in the first cycle chip select is high again.
- R8: busy is high from the cycle after acceptance for SETUP_CYC+34*HALF_DIV cycles, which covers the settling wait, the word and a chip-select-high gap of at least 2*HALF_DIV cycles before any next word.
- R9: A strobe while busy starts no word and does not disturb the running one. It sets overrun, which stays high until reset.
- R10: After reset, cs_n=1, sclk=0, busy=0, done=0 and overrun=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Sample trigger, one cycle |
| sample | input | 12 | Sample value captured with the strobe |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data, MSB first |
| busy | output | 1 | High while a word is pending or in flight |
| done | output | 1 | One-cycle pulse as chip select rises |
| overrun | output | 1 | Sticky flag for a strobe dropped while busy |

## Verification
The bench builds the block with HALF_DIV=2 and SETUP_CYC=3. This makes a word about 70 cycles long, so a sweep across several hundred sample values, including both range ends, fits comfortably. Two copies run side by side, one with SCALE_HALF=1 and one with SCALE_HALF=0, so both payload variants see every swept value. The short settling and divider settings also make exact cycle counts easy to compare for chip select, the serial clock phases, done and busy. A strobe injected mid-word exercises the overrun path.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;

    localparam int SAMPLE_W = 12;
    localparam int CTRL_W   = 4;
    localparam int FRAME_W  = SAMPLE_W + CTRL_W;
    localparam int BIT_W    = $clog2(FRAME_W);

    // channel A, unity gain, output active
    localparam logic [CTRL_W-1:0] CTRL_NIBBLE = 4'b0011;

    typedef logic [FRAME_W-1:0]  frame_t;
    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } tx_state_t;

    function automatic frame_t pack_frame(input sample_t payload);
        return {CTRL_NIBBLE, payload};
    endfunction

endpackage

// File: rtl/dft_tick.sv
module dft_tick #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] span,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = run && (cnt == span - W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/dft_delay.sv
module dft_delay #(
    parameter int W    = 4,
    parameter int LOAD = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    logic [W-1:0] cnt;

    assign expired = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (load)     cnt <= W'(LOAD);
        else if (!expired) cnt <= cnt - W'(1);
    end
endmodule

// File: rtl/dft_shreg.sv
module dft_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sr;

    assign msb = sr[W-1];

    always_ff @(posedge clk) begin
        if (rst)        sr <= '0;
        else if (load)  sr <= din;
        else if (shift) sr <= {sr[W-2:0], 1'b0};
    end
endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
    import dac_frame_pkg::*;
#(
    parameter int HALF_DIV   = 10,
    parameter int SETUP_CYC  = 400,
    parameter bit SCALE_HALF = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                cs_n,
    output logic                sclk,
    output logic                sdo,
    output logic                busy,
    output logic                done,
    output logic                overrun
);
    localparam int HC_W = $clog2(2 * HALF_DIV + 1);
    localparam int SC_W = (SETUP_CYC > 1) ? $clog2(SETUP_CYC + 1) : 1;

    tx_state_t        state;
    logic             sclk_q;
    logic [BIT_W-1:0] bit_cnt;
    logic             done_q;
    logic             ovr_q;

    logic             accept;
    logic             tick;
    logic             tick_run;
    logic [HC_W-1:0]  tick_span;
    logic             setup_over;
    logic             shift_en;
    sample_t          payload;

    generate
        if (SCALE_HALF) begin : g_half
            assign payload = sample >> 1;
        end else begin : g_full
            assign payload = sample;
        end
    endgenerate

    assign accept    = strobe && (state == ST_IDLE);
    assign tick_run  = (state == ST_SHIFT) || (state == ST_GAP);
    assign tick_span = (state == ST_GAP) ? HC_W'(2 * HALF_DIV) : HC_W'(HALF_DIV);
    assign shift_en  = (state == ST_SHIFT) && tick && sclk_q;

    dft_tick #(.W(HC_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (tick_run),
        .span (tick_span),
        .tick (tick)
    );

    dft_delay #(.W(SC_W), .LOAD(SETUP_CYC - 1)) u_setup (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .expired (setup_over)
    );

    dft_shreg #(.W(FRAME_W)) u_shreg (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .din   (pack_frame(payload)),
        .shift (shift_en),
        .msb   (sdo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            sclk_q  <= 1'b0;
            bit_cnt <= '0;
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (strobe && (state != ST_IDLE)) ovr_q <= 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (strobe) state <= ST_SETUP;
                end
                ST_SETUP: begin
                    if (setup_over) begin
                        state   <= ST_SHIFT;
                        bit_cnt <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk_q <= ~sclk_q;
                        if (sclk_q) begin
                            if (bit_cnt == BIT_W'(FRAME_W - 1)) begin
                                state  <= ST_GAP;
                                done_q <= 1'b1;
                            end else begin
                                bit_cnt <= bit_cnt + BIT_W'(1);
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cs_n    = (state != ST_SHIFT);
    assign sclk    = sclk_q;
    assign busy    = (state != ST_IDLE);
    assign done    = done_q;
    assign overrun = ovr_q;

endmodule

// File: rtl/dac_frame_tx_chk.sv
module dac_frame_tx_chk #(
    parameter int HALF_DIV = 10
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic sdo,
    input logic busy,
    input logic done,
    input logic overrun
);
    localparam int GAP_MIN = 2 * HALF_DIV;
    localparam int GW      = $clog2(GAP_MIN + 1);

    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst)                          gap_cnt <= GW'(GAP_MIN);
        else if (!cs_n)                   gap_cnt <= '0;
        else if (gap_cnt < GW'(GAP_MIN))  gap_cnt <= gap_cnt + GW'(1);
    end

    // R3: clock idles low outside a word
    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R3: data is steady while sclk stays high
    p_sdo_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && sclk && $past(sclk) && !$past(cs_n)) |-> $stable(sdo));

    // R7: done is a single pulse aligned with chip select rising
    p_done_edge_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && !$past(cs_n)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: at least one sclk period of chip select high between words
    p_cs_gap_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (gap_cnt >= GW'(GAP_MIN)));

    // R8: busy covers the active word
    p_busy_word_r8: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

    // R9: overrun is sticky
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

bind dac_frame_tx dac_frame_tx_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .sdo     (sdo),
    .busy    (busy),
    .done    (done),
    .overrun (overrun)
);

// File: tb/dac_frame_tx_tb.sv
module dac_frame_tx_tb;
    localparam int HALF  = 2;
    localparam int SETUP = 3;
    localparam int WIN   = SETUP + 34 * HALF + 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0;
    logic [11:0] sample = '0;

    logic cs_a, sclk_a, sdo_a, busy_a, done_a, ovr_a;
    logic cs_r, sclk_r, sdo_r, busy_r, done_r, ovr_r;

    int checks = 0;
    int fails  = 0;

    logic [15:0] cap_a, cap_r;
    int          nb_a, nb_r;

    always #2.5 clk = ~clk;

    dac_frame_tx #(.HALF_DIV(HALF), .SETUP_CYC(SETUP), .SCALE_HALF(1'b1)) u_dut (
        .clk(clk), .rst(rst), .strobe(strobe), .sample(sample),
        .cs_n(cs_a), .sclk(sclk_a), .sdo(sdo_a), .busy(busy_a),
        .done(done_a), .overrun(ovr_a)
    );

    dac_frame_tx #(.HALF_DIV(HALF), .SETUP_CYC(SETUP), .SCALE_HALF(1'b0)) u_raw (
        .clk(clk), .rst(rst), .strobe(strobe), .sample(sample),
        .cs_n(cs_r), .sclk(sclk_r), .sdo(sdo_r), .busy(busy_r),
        .done(done_r), .overrun(ovr_r)
    );

    always @(posedge sclk_a) if (!cs_a) begin cap_a = {cap_a[14:0], sdo_a}; nb_a++; end
    always @(posedge sclk_r) if (!cs_r) begin cap_r = {cap_r[14:0], sdo_r}; nb_r++; end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [11:0] v, input bit poke);
        int cs_first, cs_low, cs_falls, done_cnt, done_t, sh_cnt, sh_first, busy_cnt;
        logic prev_cs;
        cs_first = -1; cs_low = 0; cs_falls = 0; done_cnt = 0; done_t = -1;
        sh_cnt = 0; sh_first = -1; busy_cnt = 0; prev_cs = 1'b1;
        cap_a = '0; cap_r = '0; nb_a = 0; nb_r = 0;
        @(negedge clk); sample = v; strobe = 1'b1;
        @(negedge clk); strobe = 1'b0;
        for (int t = 1; t <= WIN; t++) begin
            if (!cs_a) begin
                cs_low++;
                if (cs_first < 0) cs_first = t;
            end
            if (prev_cs && !cs_a) cs_falls++;
            prev_cs = cs_a;
            if (done_a) begin done_cnt++; done_t = t; end
            if (sclk_a) begin sh_cnt++; if (sh_first < 0) sh_first = t; end
            if (busy_a) busy_cnt++;
            if (poke && t == 20) strobe = 1'b1;
            if (poke && t == 21) strobe = 1'b0;
            @(negedge clk);
        end
        chk(cap_a[15:12] == 4'b0011, "R1 control nibble", int'(cap_a[15:12]), 3);
        chk(cap_a == {4'b0011, v >> 1}, "R2 halved word", int'(cap_a), int'({4'b0011, v >> 1}));
        chk(cap_r == {4'b0011, v}, "R2 raw word (R1 order)", int'(cap_r), int'({4'b0011, v}));
        chk(nb_a == 16 && nb_r == 16, "R3 rising edges", nb_a, 16);
        chk(sh_first == 1 + SETUP + HALF, "R4 first rise", sh_first, 1 + SETUP + HALF);
        chk(sh_cnt == 16 * HALF, "R4 sclk high cycles", sh_cnt, 16 * HALF);
        chk(cs_first == 1 + SETUP, "R5 setup wait", cs_first, 1 + SETUP);
        chk(cs_low == 32 * HALF, "R6 cs low cycles", cs_low, 32 * HALF);
        chk(cs_falls == 1, "R9 words per strobe", cs_falls, 1);
        chk(done_cnt == 1, "R7 done count", done_cnt, 1);
        chk(done_t == 1 + SETUP + 32 * HALF, "R7 done timing", done_t, 1 + SETUP + 32 * HALF);
        chk(busy_cnt == SETUP + 34 * HALF, "R8 busy length", busy_cnt, SETUP + 34 * HALF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(cs_a && cs_r, "R10 cs_n", int'(cs_a), 1);
        chk(!sclk_a && !sclk_r, "R10 sclk", int'(sclk_a), 0);
        chk(!busy_a && !done_a, "R10 busy/done", int'(busy_a), 0);
        chk(!ovr_a && !ovr_r, "R10 overrun", int'(ovr_a), 0);

        for (int v = 0; v < 4096; v += 13) run_frame(12'(v), 1'b0);
        run_frame(12'hFFF, 1'b0);
        run_frame(12'h001, 1'b0);
        run_frame(12'h800, 1'b0);
        chk(!ovr_a, "R9 no false overrun", int'(ovr_a), 0);

        // R9 strobe while busy is dropped
        run_frame(12'hA5C, 1'b1);
        chk(ovr_a && ovr_r, "R9 overrun set", int'(ovr_a), 1);
        run_frame(12'h3C3, 1'b0);
        chk(ovr_a, "R9 overrun sticky", int'(ovr_a), 1);

        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(!ovr_a && !ovr_r, "R9 overrun cleared by reset", int'(ovr_a), 0);
        chk(cs_a && !busy_a, "R10 reset after run", int'(busy_a), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule